// File: doc/BRIEF.md
# Selectable Memory Test Pattern Generator

This block supplies the data words for a memory test. Each request produces one 16-bit word. A one-hot mode field chooses what the word is: all zeros, all ones, a checkerboard that swaps phase on every word it produces, or the next value of a linear congruential generator. The output is registered and appears one cycle after the request.

A memory test writes a pass and then reads it back. The read pass has to see the same words in the same order as the write pass. For this, the generator state and the checkerboard phase can be copied into shadow registers and reloaded from them later. A separate advance strobe steps the generator without producing a word, so the next pair of passes gets different random data. A phase-clear strobe sends the checkerboard back to its first phase; a controller pulses it when its pattern sequence wraps around to the zeros pattern. Memory access and comparison are left to the surrounding logic.

Top module: `tpat_gen`

## Requirements
- R1: After reset, `data_o` is 0x0000, the generator state is octal 123 (0x0053) and the checkerboard phase is the 0xAAAA phase.
- R2: A `next_i` pulse with `mode_sel` = 4'b0001 makes `data_o` equal to 0x0000 on the following cycle. With `mode_sel` = 4'b0010 it makes `data_o` equal to 0xFFFF.
- R3: With `mode_sel` = 4'b0100, successive `next_i` pulses give 0xAAAA (octal 125252) and 0x5555 (octal 052525) in turn. The phase changes only when a checkerboard word is produced.
- R4: A `phase_clr_i` pulse returns the checkerboard to the 0xAAAA phase without changing `data_o`. If it comes in the same cycle as a checkerboard `next_i`, that word is 0xAAAA and the following word is 0x5555.
- R5: With `mode_sel` = 4'b1000, a `next_i` pulse sets the state to x' = (2053·x + 13849) mod 65536 (octal 4005 and 33031) and puts x' on `data_o`. The sequence repeats with a period of 65536.
- R6: An `advance_i` pulse steps the generator once and leaves `data_o` unchanged. `advance_i` together with a random `next_i` steps it only once.
- R7: `save_i` copies the generator state and the checkerboard phase into shadow registers. A later `restore_i` reloads both, and the words that follow repeat the sequence that followed the save.
- R8: A `next_i` pulse with `mode_sel` = 4'b0000 leaves `data_o` unchanged and steps neither the generator nor the checkerboard phase.
- R9: When more than one mode bit is set, the lowest set bit chooses the mode: zeros, then ones, then checkerboard, then random. The modes that are not chosen keep their state.
- R10: In a cycle with `restore_i` high, `next_i`, `advance_i` and `phase_clr_i` have no effect, and `data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| mode_sel | input | 4 | One-hot mode: bit 0 zeros, bit 1 ones, bit 2 checkerboard, bit 3 random |
| next_i | input | 1 | Produce one word in the selected mode |
| advance_i | input | 1 | Step the generator without producing a word |
| phase_clr_i | input | 1 | Return the checkerboard to its 0xAAAA phase |
| save_i | input | 1 | Copy the generator state and checkerboard phase to the shadow registers |
| restore_i | input | 1 | Reload the generator state and checkerboard phase from the shadow registers |
| data_o | output | 16 | Registered test word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, seed octal 123, increment octal 33031, and shifts of 2 and 11. At this width the whole generator period of 65536 words can be run with `next_i` held high. Each of those words is checked against a multiply-and-add model in the bench, and the last one must equal the state the run started from. A short directed part covers the rest: strobes arriving together, more than one mode bit set, and save and restore with both the checkerboard and random words between them.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_ZERO = 3'd1,
    SEL_ONE  = 3'd2,
    SEL_CHK  = 3'd3,
    SEL_RND  = 3'd4
  } sel_e;

  // Lowest set bit wins: zeros, ones, checkerboard, random.
  function automatic sel_e decode_mode(input logic [3:0] m);
    sel_e s;
    if (m[0])      s = SEL_ZERO;
    else if (m[1]) s = SEL_ONE;
    else if (m[2]) s = SEL_CHK;
    else if (m[3]) s = SEL_RND;
    else           s = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/tpat_rst_sync.sv
module tpat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/tpat_lcg.sv
module tpat_lcg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = W'(16'o123),
  parameter logic [W-1:0] INC  = W'(16'o33031),
  parameter int          SH_A = 2,
  parameter int          SH_B = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         save,
  input  logic         restore,
  output logic [W-1:0] state_o,
  output logic [W-1:0] stepped_o
);

  localparam logic [W-1:0] MUL = W'((1 << SH_A) + (1 << SH_B) + 1);

  logic [W-1:0] state_q, state_d;
  logic [W-1:0] shadow_q, shadow_d;

  // Multiply by a constant with two shifts and two adds.
  assign stepped_o = state_q + (state_q << SH_A) + (state_q << SH_B) + INC;

  always_comb begin
    state_d  = state_q;
    shadow_d = shadow_q;
    if (restore)   state_d = shadow_q;
    else if (step) state_d = stepped_o;
    if (save)      shadow_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEED;
      shadow_q <= SEED;
    end else begin
      state_q  <= state_d;
      shadow_q <= shadow_d;
    end
  end

  assign state_o = state_q;

  // R5: one step equals multiply-and-add
  a_r5_lcg_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restore) |=> state_q == $past(state_q) * MUL + INC);

  // R7: restore reloads the shadow copy
  a_r7_restore_lcg: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> state_q == $past(shadow_q));

  // R8: no step and no restore keeps the state
  a_r8_lcg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restore) |=> $stable(state_q));

endmodule

// File: rtl/tpat_chk.sv
module tpat_chk #(
  parameter int           W     = 16,
  parameter logic [W-1:0] PAT_A = W'(16'o125252)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         flip,
  input  logic         save,
  input  logic         restore,
  output logic [W-1:0] word_o
);

  localparam logic [W-1:0] PAT_B = ~PAT_A;

  logic phase_q, phase_d, phase_eff;
  logic shadow_q, shadow_d;

  assign phase_eff = clr ? 1'b0 : phase_q;
  assign word_o    = phase_eff ? PAT_B : PAT_A;

  always_comb begin
    phase_d  = phase_q;
    shadow_d = shadow_q;
    if (restore) phase_d = shadow_q;
    else         phase_d = phase_eff ^ flip;
    if (save)    shadow_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      shadow_q <= shadow_d;
    end
  end

  // R3: each checkerboard word changes the phase
  a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !restore && !clr) |=> phase_q != $past(phase_q));

  // R4: a clear without a word leaves the first phase
  a_r4_phase_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !flip && !restore) |=> !phase_q);

  // R7: restore reloads the shadow phase
  a_r7_restore_phase: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> phase_q == $past(shadow_q));

endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
  import tpat_pkg::*;
#(
  parameter int           W     = 16,
  parameter logic [W-1:0] SEED  = W'(16'o123),
  parameter logic [W-1:0] INC   = W'(16'o33031),
  parameter int           SH_A  = 2,
  parameter int           SH_B  = 11,
  parameter logic [W-1:0] PAT_A = W'(16'o125252)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode_sel,
  input  logic         next_i,
  input  logic         advance_i,
  input  logic         phase_clr_i,
  input  logic         save_i,
  input  logic         restore_i,
  output logic [W-1:0] data_o
);

  logic         rst_s;
  sel_e         sel;
  logic         emit, step, flip, clr;
  logic [W-1:0] lcg_state, lcg_next, chk_word;
  logic [W-1:0] data_q, data_d;

  tpat_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_s)
  );

  assign sel  = decode_mode(mode_sel);
  assign emit = next_i && !restore_i && (sel != SEL_NONE);
  assign step = !restore_i && (advance_i || (next_i && sel == SEL_RND));
  assign flip = emit && (sel == SEL_CHK);
  assign clr  = phase_clr_i && !restore_i;

  tpat_lcg #(.W(W), .SEED(SEED), .INC(INC), .SH_A(SH_A), .SH_B(SH_B)) u_lcg (
    .clk       (clk),
    .rst_n     (rst_s),
    .step      (step),
    .save      (save_i),
    .restore   (restore_i),
    .state_o   (lcg_state),
    .stepped_o (lcg_next)
  );

  tpat_chk #(.W(W), .PAT_A(PAT_A)) u_chk (
    .clk     (clk),
    .rst_n   (rst_s),
    .clr     (clr),
    .flip    (flip),
    .save    (save_i),
    .restore (restore_i),
    .word_o  (chk_word)
  );

  always_comb begin
    case (sel)
      SEL_ZERO: data_d = '0;
      SEL_ONE:  data_d = '1;
      SEL_CHK:  data_d = chk_word;
      SEL_RND:  data_d = lcg_next;
      default:  data_d = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)    data_q <= '0;
    else if (emit) data_q <= data_d;
  end

  assign data_o = data_q;

  // R2: zeros and ones modes
  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (next_i && !restore_i && mode_sel[0]) |=> data_o == '0);
  a_r2_ones: assert property (@(posedge clk) disable iff (!rst_s)
    (next_i && !restore_i && mode_sel == 4'b0010) |=> data_o == '1);

  // R8: without a valid request the output holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (!next_i || mode_sel == 4'b0000) |=> $stable(data_o));

  // R10: restore blocks word production
  a_r10_restore_hold: assert property (@(posedge clk) disable iff (!rst_s)
    restore_i |=> $stable(data_o));

  // R5: a random word equals the new generator state
  a_r5_rnd_word: assert property (@(posedge clk) disable iff (!rst_s)
    (next_i && !restore_i && mode_sel == 4'b1000) |=> data_o == lcg_state);

endmodule

// File: tb/tpat_gen_test.sv
`timescale 1ns/1ps
module tpat_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_sel = 4'b0000;
  logic        next_i = 1'b0, advance_i = 1'b0, phase_clr_i = 1'b0;
  logic        save_i = 1'b0, restore_i = 1'b0;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] MZ = 4'b0001, MO = 4'b0010, MC = 4'b0100, MR = 4'b1000;

  always #4 clk = ~clk;

  tpat_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .next_i(next_i),
    .advance_i(advance_i), .phase_clr_i(phase_clr_i), .save_i(save_i),
    .restore_i(restore_i), .data_o(data_o)
  );

  function automatic logic [15:0] lcg(input logic [15:0] x);
    int unsigned t;
    t = 32'(x) * 2053 + 13849;
    return t[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] m, input logic n, input logic a,
                    input logic c, input logic s, input logic r);
    @(negedge clk);
    mode_sel = m; next_i = n; advance_i = a; phase_clr_i = c; save_i = s; restore_i = r;
    @(negedge clk);
    next_i = 0; advance_i = 0; phase_clr_i = 0; save_i = 0; restore_i = 0;
  endtask

  logic [15:0] x, xs, x0, prev;
  logic        ph, phs;
  logic [15:0] rec [6];

  function automatic logic [15:0] cw(input logic p);
    return p ? 16'h5555 : 16'hAAAA;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    x = 16'o123; ph = 1'b0;

    check("R1 reset output", data_o, 16'h0000);
    op(MR, 1, 0, 0, 0, 0); x = lcg(x);
    check("R1 seed / R5 first word", data_o, x);

    op(MZ, 1, 0, 0, 0, 0); check("R2 zeros", data_o, 16'h0000);
    op(MO, 1, 0, 0, 0, 0); check("R2 ones", data_o, 16'hFFFF);

    for (int i = 0; i < 4; i++) begin
      op(MC, 1, 0, 0, 0, 0); check("R3 checker", data_o, cw(ph)); ph = ~ph;
    end
    op(MC, 1, 0, 0, 0, 0); check("R3 checker", data_o, cw(ph)); ph = ~ph;
    prev = data_o;
    op(MC, 0, 0, 1, 0, 0); ph = 0;
    check("R4 clear holds output", data_o, prev);
    op(MC, 1, 0, 0, 0, 0); check("R4 after clear", data_o, 16'hAAAA); ph = 1;
    op(MC, 1, 0, 1, 0, 0); check("R4 clear with word", data_o, 16'hAAAA);
    op(MC, 1, 0, 0, 0, 0); check("R4 word after clear", data_o, 16'h5555); ph = 0;

    prev = data_o;
    op(MR, 0, 1, 0, 0, 0); x = lcg(x);
    check("R6 advance holds output", data_o, prev);
    op(MR, 1, 0, 0, 0, 0); x = lcg(x); check("R6 step after advance", data_o, x);
    op(MR, 1, 1, 0, 0, 0); x = lcg(x); check("R6 advance with next", data_o, x);
    op(MR, 1, 0, 0, 0, 0); x = lcg(x); check("R6 single step", data_o, x);

    op(MO, 1, 0, 0, 1, 0); xs = x; phs = ph;
    for (int i = 0; i < 6; i++) begin
      op((i % 2 == 0) ? MR : MC, 1, 0, 0, 0, 0);
      rec[i] = data_o;
      if (i % 2 == 0) begin x = lcg(x); check("R7 first pass", data_o, x); end
      else begin check("R7 first pass", data_o, cw(ph)); ph = ~ph; end
    end
    prev = data_o;
    op(MR, 0, 0, 0, 0, 1); x = xs; ph = phs;
    check("R10 restore holds output", data_o, prev);
    for (int i = 0; i < 6; i++) begin
      op((i % 2 == 0) ? MR : MC, 1, 0, 0, 0, 0);
      check("R7 replay", data_o, rec[i]);
      if (i % 2 == 0) x = lcg(x); else ph = ~ph;
    end

    prev = data_o;
    op(4'b0000, 1, 0, 0, 0, 0); check("R8 no mode holds", data_o, prev);
    op(MR, 1, 0, 0, 0, 0); x = lcg(x); check("R8 generator not stepped", data_o, x);
    op(MC, 1, 0, 0, 0, 0); check("R8 phase not stepped", data_o, cw(ph)); ph = ~ph;

    op(4'b1100, 1, 0, 0, 0, 0); check("R9 checker over random", data_o, cw(ph)); ph = ~ph;
    op(MR, 1, 0, 0, 0, 0); x = lcg(x); check("R9 random untouched", data_o, x);
    op(4'b0011, 1, 0, 0, 0, 0); check("R9 zeros over ones", data_o, 16'h0000);
    op(4'b1110, 1, 0, 0, 0, 0); check("R9 ones first", data_o, 16'hFFFF);
    op(MC, 1, 0, 0, 0, 0); check("R9 phase untouched", data_o, cw(ph)); ph = ~ph;

    op(MO, 0, 0, 0, 1, 0); xs = x; phs = ph;
    op(MR, 1, 0, 0, 0, 0); x = lcg(x);
    op(MC, 1, 0, 0, 0, 0); ph = ~ph;
    prev = data_o;
    op(MR, 1, 1, 1, 0, 1); x = xs; ph = phs;
    check("R10 restore blocks next", data_o, prev);
    op(MR, 1, 0, 0, 0, 0); x = lcg(x); check("R10 state from shadow", data_o, x);
    op(MC, 1, 0, 0, 0, 0); check("R10 phase from shadow", data_o, cw(ph)); ph = ~ph;

    x0 = x;
    @(negedge clk); mode_sel = MR; next_i = 1;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk); x = lcg(x);
      check("R5 sweep", data_o, x);
    end
    next_i = 0;
    check("R5 full period", data_o, x0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule